// File: doc/BRIEF.md
# Torus Adaptive Route and Virtual-Channel Selector

This block makes the per-hop routing decision for one router of a two-dimensional torus that has four neighbour ports (X+, X-, Y+, Y-) and one local port. Each arriving header carries an index into a configuration table. The table entry supplies the destination coordinates, an adaptivity-allowed bit and other routing bits, and is protected by one parity bit. From the entry, the node's own coordinates, the incoming virtual channel and the direction of the last hop, the block chooses an output port and a virtual channel. It then rewrites the header's routing field to match.

Each physical link carries three virtual channels: one adaptive channel and two escape channels. A packet takes the adaptive channel along a minimal direction whenever one of those directions reports a free adaptive buffer. If none does, the packet drops into an escape network that resolves X before Y and uses a dateline scheme on two channels within each dimension. A packet on the escape network can return to the adaptive channel at any later hop. The lookup takes one cycle in a table that block RAM can hold, and the decision is registered one cycle later.

Top module: `torus_route_sel`

## Requirements
- R1: A table entry written through the write port is used by every later lookup of that index, and overwriting it changes the decision. The outputs for a header presented with `hdr_valid` in cycle k appear after the second rising edge, and `out_valid` stays low after the first.
- R2: Entries use even parity over all 24 bits, with bit 23 as the parity bit. A lookup whose entry fails parity raises `out_err` for one cycle and leaves `out_valid` low.
- R3: When the destination equals (`my_x`, `my_y`), the packet goes to port 4 (local) and keeps its incoming VC code unchanged.
- R4: With adaptivity allowed, the eligible directions are the minimal X and Y directions that are still needed and have a nonzero adaptive free count. The block picks the eligible direction with the larger count and resolves a tie toward X. It outputs VC code 2 (adaptive). Counts on non-minimal ports have no effect.
- R5: When the entry's adaptivity bit (bit 3) is clear, VC code 2 is never chosen for a neighbour port, whatever the free counts.
- R6: When no minimal direction is eligible for the adaptive channel, the escape route takes X while the X coordinate still differs and only then Y. An escape packet returns to VC 2 as soon as a minimal adaptive buffer is free.
- R7: An escape hop uses VC1 (code 1) unless the packet has crossed the wraparound link in the dimension it now travels. It counts as crossed when it just arrived moving plus at coordinate 0 or moving minus at coordinate SIZE-1 of that dimension, or when it arrived on VC0 (code 0) moving in that same dimension. A crossed packet uses VC0.
- R8: In each dimension the minimal direction is plus when the forward distance (dest - cur) mod SIZE is at most SIZE/2 (integer division), otherwise minus. Port codes are 0 = X+, 1 = X-, 2 = Y+, 3 = Y-, 4 = local.
- R9: The output header is {port[1:0], entry[11:0], vc[1:0]}: the direction field holds the low two bits of the chosen port, the VC field holds the chosen VC, and the destination X (entry[11:8]), destination Y (entry[7:4]), adaptivity bit (entry[3]), I/O bit (entry[2]) and reserved bits (entry[1:0]) are copied unchanged.
- R10: After synchronous reset, `out_valid`, `out_err`, `out_port`, `out_vc` and `out_hdr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_x | input | 4 | X coordinate of this node |
| my_y | input | 4 | Y coordinate of this node |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | IDX_W | Table write index |
| tbl_wdata | input | 24 | Table write data with parity in bit 23 |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_idx | input | IDX_W | Table index carried by the header |
| hdr_vc | input | 2 | Incoming VC code (0 VC0, 1 VC1, 2 adaptive) |
| hdr_in_dir | input | 3 | Direction of travel on the last hop (port code; 4 or more = injected) |
| adapt_free | input | 4*CNT_W | Adaptive free-buffer counts, port 0 in the low bits |
| out_valid | output | 1 | Decision valid |
| out_port | output | 3 | Chosen output port |
| out_vc | output | 2 | Chosen VC code |
| out_hdr | output | 16 | Rewritten header routing field |
| out_err | output | 1 | Parity error on the looked-up entry |

## Verification
The bench builds the block with a 6 by 5 torus. The even ring has a destination exactly half-way round and the odd ring has none, so both outcomes of the distance comparison are reached, along with the wraparound on each side. The table is 32 entries deep, which lets the top index be rewritten and read back, and 3-bit free counts make tie, zero and maximum count cases short to set up.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;
  localparam int ENTRY_W = 24;
  localparam int HDR_W   = 16;
  localparam int COORD_W = 4;
  localparam int NPORT   = 4;

  typedef enum logic [2:0] {
    P_XP  = 3'd0,
    P_XM  = 3'd1,
    P_YP  = 3'd2,
    P_YM  = 3'd3,
    P_LOC = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    VC_E0 = 2'd0,
    VC_E1 = 2'd1,
    VC_AD = 2'd2,
    VC_RS = 2'd3
  } vc_e;
endpackage

// File: rtl/torus_cfg_table.sv
module torus_cfg_table #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 24,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual-port RAM with registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/torus_min_dir.sv
module torus_min_dir #(
  parameter int SIZE = 8,
  parameter int W    = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] dst,
  output logic         need,
  output logic         go_plus
);
  localparam logic [W:0] RING = (W+1)'(SIZE);
  localparam logic [W:0] HALF = (W+1)'(SIZE / 2);

  logic [W:0] fwd;

  always_comb begin
    if (dst >= cur) fwd = {1'b0, dst} - {1'b0, cur};
    else            fwd = {1'b0, dst} + RING - {1'b0, cur};
    need    = (dst != cur);
    go_plus = (fwd <= HALF);
  end
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
  import torus_rt_pkg::*;
#(
  parameter int X_SIZE    = 8,
  parameter int Y_SIZE    = 8,
  parameter int TBL_DEPTH = 128,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = $clog2(TBL_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [COORD_W-1:0]     my_x,
  input  logic [COORD_W-1:0]     my_y,
  input  logic                   tbl_we,
  input  logic [IDX_W-1:0]       tbl_waddr,
  input  logic [ENTRY_W-1:0]     tbl_wdata,
  input  logic                   hdr_valid,
  input  logic [IDX_W-1:0]       hdr_idx,
  input  logic [1:0]             hdr_vc,
  input  logic [2:0]             hdr_in_dir,
  input  logic [NPORT*CNT_W-1:0] adapt_free,
  output logic                   out_valid,
  output logic [2:0]             out_port,
  output logic [1:0]             out_vc,
  output logic [HDR_W-1:0]       out_hdr,
  output logic                   out_err
);
  localparam logic [COORD_W-1:0] X_LAST = COORD_W'(X_SIZE - 1);
  localparam logic [COORD_W-1:0] Y_LAST = COORD_W'(Y_SIZE - 1);

  // Stage 1: table read and header side information.
  logic [ENTRY_W-1:0] ent;
  logic               s1_valid;
  logic [1:0]         s1_vc;
  logic [2:0]         s1_dir;

  torus_cfg_table #(.DEPTH(TBL_DEPTH), .WIDTH(ENTRY_W), .AW(IDX_W)) u_tbl (
    .clk  (clk),
    .we   (tbl_we),
    .waddr(tbl_waddr),
    .wdata(tbl_wdata),
    .raddr(hdr_idx),
    .rdata(ent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_vc    <= 2'd0;
      s1_dir   <= 3'd0;
    end else begin
      s1_valid <= hdr_valid;
      s1_vc    <= hdr_vc;
      s1_dir   <= hdr_in_dir;
    end
  end

  // Entry fields.
  logic                perr;
  logic [COORD_W-1:0]  dst_x, dst_y;
  logic                adapt_ok;

  assign perr     = ^ent;
  assign dst_x    = ent[11:8];
  assign dst_y    = ent[7:4];
  assign adapt_ok = ent[3];

  // Minimal direction per dimension.
  logic x_need, x_plus, y_need, y_plus;

  torus_min_dir #(.SIZE(X_SIZE), .W(COORD_W)) u_mdx (
    .cur(my_x), .dst(dst_x), .need(x_need), .go_plus(x_plus));
  torus_min_dir #(.SIZE(Y_SIZE), .W(COORD_W)) u_mdy (
    .cur(my_y), .dst(dst_y), .need(y_need), .go_plus(y_plus));

  // Decision logic.
  port_e            x_port, y_port, sel_port;
  vc_e              sel_vc;
  logic [CNT_W-1:0] cx, cy;
  logic             x_ok, y_ok, in_x, in_y, crossed_x, crossed_y;

  always_comb begin
    x_port = x_plus ? P_XP : P_XM;
    y_port = y_plus ? P_YP : P_YM;
    cx     = adapt_free[int'(x_port)*CNT_W +: CNT_W];
    cy     = adapt_free[int'(y_port)*CNT_W +: CNT_W];
    x_ok   = adapt_ok && x_need && (cx != '0);
    y_ok   = adapt_ok && y_need && (cy != '0);

    in_x = (s1_dir == P_XP) || (s1_dir == P_XM);
    in_y = (s1_dir == P_YP) || (s1_dir == P_YM);
    crossed_x = ((s1_dir == P_XP) && (my_x == '0)) ||
                ((s1_dir == P_XM) && (my_x == X_LAST)) ||
                (in_x && (s1_vc == VC_E0));
    crossed_y = ((s1_dir == P_YP) && (my_y == '0)) ||
                ((s1_dir == P_YM) && (my_y == Y_LAST)) ||
                (in_y && (s1_vc == VC_E0));

    if (!x_need && !y_need) begin
      sel_port = P_LOC;
      sel_vc   = vc_e'(s1_vc);
    end else if (x_ok || y_ok) begin
      sel_vc   = VC_AD;
      sel_port = (x_ok && (!y_ok || cx >= cy)) ? x_port : y_port;
    end else if (x_need) begin
      sel_port = x_port;
      sel_vc   = crossed_x ? VC_E0 : VC_E1;
    end else begin
      sel_port = y_port;
      sel_vc   = crossed_y ? VC_E0 : VC_E1;
    end
  end

  // Stage 2: registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_port  <= 3'd0;
      out_vc    <= 2'd0;
      out_hdr   <= '0;
    end else begin
      out_valid <= s1_valid && !perr;
      out_err   <= s1_valid && perr;
      if (s1_valid && !perr) begin
        out_port <= sel_port;
        out_vc   <= sel_vc;
        out_hdr  <= {sel_port[1:0], ent[11:0], sel_vc};
      end
    end
  end

  // Checks on the block's own behaviour.
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_err) |-> $past(hdr_valid, 2));

  assert_err_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    out_err |-> !out_valid);

  assert_local_vc_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port == 3'd4) |-> (out_vc == $past(hdr_vc, 2)));

  assert_adapt_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port != 3'd4 && out_vc == 2'd2) |-> out_hdr[5]);

  assert_port_range_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_port <= 3'd4));

  assert_escape_code_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port != 3'd4) |-> (out_vc != 2'd3));

  assert_hdr_fields_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hdr[15:14] == out_port[1:0] && out_hdr[1:0] == out_vc));
endmodule

// File: tb/torus_route_sel_tb.sv
`timescale 1ns/1ps
module torus_route_sel_tb;
  localparam int XS  = 6;
  localparam int YS  = 5;
  localparam int DEP = 32;
  localparam int CW  = 3;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    my_x, my_y;
  logic          tbl_we;
  logic [AW-1:0] tbl_waddr;
  logic [23:0]   tbl_wdata;
  logic          hdr_valid;
  logic [AW-1:0] hdr_idx;
  logic [1:0]    hdr_vc;
  logic [2:0]    hdr_in_dir;
  logic [4*CW-1:0] adapt_free;
  logic          out_valid;
  logic [2:0]    out_port;
  logic [1:0]    out_vc;
  logic [15:0]   out_hdr;
  logic          out_err;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [23:0] shadow [DEP];

  always #10 clk = ~clk;

  torus_route_sel #(.X_SIZE(XS), .Y_SIZE(YS), .TBL_DEPTH(DEP), .CNT_W(CW), .IDX_W(AW)) u_dut (
    .clk(clk), .rst(rst), .my_x(my_x), .my_y(my_y),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .hdr_valid(hdr_valid), .hdr_idx(hdr_idx), .hdr_vc(hdr_vc), .hdr_in_dir(hdr_in_dir),
    .adapt_free(adapt_free), .out_valid(out_valid), .out_port(out_port),
    .out_vc(out_vc), .out_hdr(out_hdr), .out_err(out_err));

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [1:0] dir, input logic [3:0] dx,
                                     input logic [3:0] dy, input logic ad, input logic io);
    logic [22:0] body;
    body = {3'b101, 6'h2A, dir, dx, dy, ad, io, 2'b10};
    return {^body, body};
  endfunction

  task automatic put(input int idx, input logic [23:0] e);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = AW'(idx); tbl_wdata = e;
    @(negedge clk);
    tbl_we = 1'b0;
    shadow[idx] = e;
  endtask

  task automatic cred(input int xp, input int xm, input int yp, input int ym);
    adapt_free = {CW'(ym), CW'(yp), CW'(xm), CW'(xp)};
  endtask

  task automatic route(input int idx, input int vc, input int dir,
                       input int ep, input int ev, input string tag);
    logic [15:0] eh;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_idx = AW'(idx); hdr_vc = 2'(vc); hdr_in_dir = 3'(dir);
    @(negedge clk);
    hdr_valid = 1'b0;
    chk(out_valid == 1'b0, "R1", "valid one cycle early", longint'(out_valid), 0);
    @(negedge clk);
    eh = {2'(ep), shadow[idx][11:0], 2'(ev)};
    chk(out_valid == 1'b1 && out_err == 1'b0, tag, "valid", longint'(out_valid), 1);
    chk(out_port == 3'(ep), tag, "port", longint'(out_port), longint'(ep));
    chk(out_vc == 2'(ev), tag, "vc", longint'(out_vc), longint'(ev));
    chk(out_hdr == eh, "R9", "header", longint'(out_hdr), longint'(eh));
  endtask

  task automatic t_reset();
    chk(out_valid == 0 && out_err == 0, "R10", "flags", longint'({out_valid, out_err}), 0);
    chk(out_port == 0 && out_vc == 0, "R10", "port/vc", longint'({out_port, out_vc}), 0);
    chk(out_hdr == 0, "R10", "header", longint'(out_hdr), 0);
  endtask

  task automatic t_local();
    my_x = 4'd2; my_y = 4'd2; cred(7, 7, 7, 7);
    put(0, mk(2'd0, 4'd2, 4'd2, 1'b1, 1'b0));
    route(0, 1, 4, 4, 1, "R3");
    route(0, 0, 4, 4, 0, "R3");
    route(0, 2, 0, 4, 2, "R3");
  endtask

  task automatic t_mindir();
    my_x = 4'd2; my_y = 4'd2; cred(0, 0, 0, 0);
    put(1, mk(2'd0, 4'd5, 4'd2, 1'b0, 1'b0));  // distance 3 = 6/2 -> plus
    put(2, mk(2'd0, 4'd0, 4'd2, 1'b0, 1'b0));  // distance 4 -> minus
    put(3, mk(2'd0, 4'd2, 4'd4, 1'b0, 1'b0));  // distance 2 = 5/2 -> plus
    put(4, mk(2'd0, 4'd2, 4'd0, 1'b0, 1'b0));  // distance 3 -> minus
    route(1, 1, 4, 0, 1, "R8");
    route(2, 1, 4, 1, 1, "R8");
    route(3, 1, 4, 2, 1, "R8");
    route(4, 1, 4, 3, 1, "R8");
  endtask

  task automatic t_adaptive();
    my_x = 4'd2; my_y = 4'd2;
    put(5, mk(2'd0, 4'd4, 4'd3, 1'b1, 1'b0));
    put(6, mk(2'd0, 4'd0, 4'd0, 1'b1, 1'b0));
    cred(3, 0, 5, 0); route(5, 1, 4, 2, 2, "R4");
    cred(5, 0, 5, 0); route(5, 1, 4, 0, 2, "R4");
    cred(0, 0, 1, 0); route(5, 1, 4, 2, 2, "R4");
    cred(2, 0, 0, 0); route(5, 1, 4, 0, 2, "R4");
    cred(1, 7, 2, 7); route(5, 1, 4, 2, 2, "R4");
    cred(7, 4, 7, 4); route(6, 1, 4, 1, 2, "R4");
  endtask

  task automatic t_noadapt();
    my_x = 4'd2; my_y = 4'd2; cred(7, 7, 7, 7);
    put(7, mk(2'd0, 4'd4, 4'd3, 1'b0, 1'b0));
    route(7, 1, 4, 0, 1, "R5");
    route(7, 2, 0, 0, 1, "R5");
  endtask

  task automatic t_escape();
    my_x = 4'd2; my_y = 4'd2; cred(0, 7, 0, 7);
    put(8, mk(2'd0, 4'd2, 4'd3, 1'b1, 1'b0));
    route(5, 1, 4, 0, 1, "R6");
    route(8, 1, 4, 2, 1, "R6");
    cred(0, 0, 3, 0);
    route(5, 0, 0, 2, 2, "R6");
  endtask

  task automatic t_escvc();
    cred(0, 0, 0, 0);
    put(9,  mk(2'd0, 4'd1, 4'd2, 1'b1, 1'b0));
    put(10, mk(2'd0, 4'd4, 4'd2, 1'b1, 1'b0));
    put(11, mk(2'd0, 4'd2, 4'd1, 1'b1, 1'b0));
    my_x = 4'd0; my_y = 4'd2; route(9, 1, 0, 0, 0, "R7");
    my_x = 4'd3; my_y = 4'd2;
    route(5, 0, 0, 0, 0, "R7");
    route(5, 1, 0, 0, 1, "R7");
    route(5, 0, 2, 0, 1, "R7");
    my_x = 4'd5; my_y = 4'd2; route(10, 1, 1, 1, 0, "R7");
    my_x = 4'd2; my_y = 4'd0; route(11, 1, 2, 2, 0, "R7");
  endtask

  task automatic t_parity();
    my_x = 4'd2; my_y = 4'd2; cred(1, 1, 1, 1);
    put(12, mk(2'd0, 4'd3, 4'd2, 1'b1, 1'b0) ^ 24'h800000);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_idx = AW'(12); hdr_vc = 2'd1; hdr_in_dir = 3'd4;
    @(negedge clk);
    hdr_valid = 1'b0;
    @(negedge clk);
    chk(out_err == 1'b1, "R2", "err", longint'(out_err), 1);
    chk(out_valid == 1'b0, "R2", "valid on bad entry", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_err == 1'b0, "R2", "err one cycle", longint'(out_err), 0);
  endtask

  task automatic t_hdr();
    my_x = 4'd2; my_y = 4'd2; cred(4, 0, 0, 0);
    put(13, mk(2'd3, 4'd3, 4'd2, 1'b1, 1'b1));
    route(13, 1, 4, 0, 2, "R9");
  endtask

  task automatic t_table();
    my_x = 4'd2; my_y = 4'd2; cred(0, 0, 0, 0);
    put(31, mk(2'd0, 4'd3, 4'd2, 1'b0, 1'b0));
    route(31, 1, 4, 0, 1, "R1");
    put(31, mk(2'd0, 4'd1, 4'd2, 1'b0, 1'b0));
    route(31, 1, 4, 1, 1, "R1");
  endtask

  initial begin
    rst = 1'b1; tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
    hdr_valid = 1'b0; hdr_idx = '0; hdr_vc = '0; hdr_in_dir = 3'd4;
    my_x = 4'd2; my_y = 4'd2; adapt_free = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_local();
    t_mindir();
    t_adaptive();
    t_noadapt();
    t_escape();
    t_escvc();
    t_parity();
    t_hdr();
    t_table();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule